// File: doc/BRIEF.md
# UART Receiver Standby, Wakeup and Idle-Line Logic

This block sits next to a UART receiver core, which does bit sampling and framing. The core reports one strobe per received bit with its line level, and one event per finished character with the data word, its most significant bit and whether a valid stop bit was seen. From these inputs the block decides whether each character is delivered to the holding register. It counts consecutive idle bits to detect an idle line. It keeps the receive-full, overrun and idle flags, and it combines them into one receiver interrupt.

Software can put the receiver into standby with a one-cycle request. In standby, characters are not delivered, the idle flag does not set and the interrupt stays low. Hardware leaves standby on its own when the selected wakeup condition occurs, and it gives a one-cycle pulse when it does. The wakeup condition is either an idle line or a character whose most significant bit is set. Flags are cleared by a two-step sequence: a status read, then a later access to the data register. Only the flags that were set at the status read are cleared.

Top module: `rxw_wake_idle`

## Requirements
- R1: After reset, rx_full, rx_ovr, rx_idle, standby, sby_hw_clr and rx_irq are 0 and rd_data is 0.
- R2: When a character completes (char_done=1) outside standby and rx_full is 0, rx_full sets and rd_data takes rx_data on the next cycle.
- R3: When a character is accepted while rx_full is still set and is not being cleared, rx_ovr sets, the new character is dropped and rd_data keeps the held value.
- R4: A dr_acc pulse clears exactly the flags that were 1 at the most recent st_rd pulse. A dr_acc with no st_rd before it clears nothing. A flag that sets after the st_rd survives the dr_acc.
- R5: The idle event fires on the bit strobe that completes a run of consecutive 1 bits. The run is 10 bits long with ctl_nine=0 and 11 bits long with ctl_nine=1.
- R6: With ctl_ilt=0, every 1 bit counts, including trailing 1 data bits and the stop bit. With ctl_ilt=1, counting starts only after a char_done that has stop_ok=1, and the stop bit itself is not counted.
- R7: rx_idle sets on an idle event only if at least one character has completed since rx_idle was last cleared.
- R8: sby_req sets standby. While in standby and not woken, a character does not set rx_full or change rd_data, an idle event does not set rx_idle, and rx_irq is 0.
- R9: With ctl_wake_sel=0, an idle event in standby clears standby and gives a one-cycle pulse on sby_hw_clr. That event does not set rx_idle.
- R10: With ctl_wake_sel=1, a character with char_msb=1 clears standby (with a one-cycle sby_hw_clr pulse) and is delivered as in R2. A character with char_msb=0 leaves the block in standby.
- R11: Outside standby, rx_irq is (rie and (rx_full or rx_ovr)) or (ilie and rx_idle).
- R12: A bit strobe with level 0 restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | Strobe for one received bit time |
| bit_level | input | 1 | Line level sampled for that bit |
| char_done | input | 1 | Character finished, coincident with its stop-bit strobe |
| stop_ok | input | 1 | Stop bit of the finished character was 1 |
| char_msb | input | 1 | Most significant data bit of the finished character |
| rx_data | input | DATA_W | Data word of the finished character |
| ctl_wake_sel | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| ctl_ilt | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| ctl_nine | input | 1 | 1 selects 9-bit characters |
| sby_req | input | 1 | One-cycle software request to enter standby |
| rie | input | 1 | Enable for receive-full and overrun interrupts |
| ilie | input | 1 | Enable for idle interrupt |
| st_rd | input | 1 | Status register read strobe |
| dr_acc | input | 1 | Data register access strobe |
| rx_full | output | 1 | Holding register has an unread character |
| rx_ovr | output | 1 | A character was lost to a full holding register |
| rx_idle | output | 1 | Idle line detected |
| rd_data | output | DATA_W | Held character |
| rx_irq | output | 1 | Combined receiver interrupt |
| standby | output | 1 | Receiver is in standby |
| sby_hw_clr | output | 1 | One-cycle pulse when hardware ends standby |

## Verification
The bench builds the block with its default parameters: a 9-bit data path and idle thresholds of 10 and 11 bits. With these values both character lengths can be reached through ctl_nine, and the threshold can be checked one bit short of the limit and exactly at it in each mode. Characters of all ones show the difference between the two idle-count start points. Both wakeup methods are tested, along with the interleavings of the clear sequence.

// File: rtl/rxw_pkg.sv
// Package: shared types for the receiver wakeup and idle logic.
// Assumes nothing beyond standard SystemVerilog packed types.
package rxw_pkg;

    // Wakeup method encoding carried by ctl_wake_sel.
    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_e;

    // Snapshot of the clearable flags taken on a status read.
    typedef struct packed {
        logic full;
        logic ovr;
        logic idle;
    } rxw_snap_t;

    // Larger of two idle thresholds, used to size the counter.
    function automatic int unsigned max_bits(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxw_idle_cnt.sv
// Module: idle-line counter.
// Counts consecutive 1 bits reported by the receiver core. The count starts
// either right away (after the start bit) or only after a valid stop bit.
// It emits a one-cycle idle event on the strobe that completes a full
// character time of ones. Assumes char_done coincides with the stop-bit strobe.
module rxw_idle_cnt #(
    parameter int unsigned IDLE_BITS8 = 10,
    parameter int unsigned IDLE_BITS9 = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bit_level,
    input  logic char_done,
    input  logic stop_ok,
    input  logic ilt,
    input  logic nine,
    output logic idle_evt
);
    localparam int unsigned MAX_BITS = rxw_pkg::max_bits(IDLE_BITS8, IDLE_BITS9);
    localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;
    logic             armed;
    logic             count_en;
    logic             stop_arm;

    // Select the threshold for the current character length.
    assign thr      = nine ? CNT_W'(IDLE_BITS9) : CNT_W'(IDLE_BITS8);
    // Counting is open at all times, or only after an armed stop bit.
    assign count_en = !ilt || armed;
    // A valid stop bit starts the count window in after-stop mode.
    assign stop_arm = ilt && char_done && stop_ok;

    // Track the run of ones and raise the idle event at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (stop_arm) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (bit_tick) begin
                if (!bit_level) begin
                    cnt   <= '0;
                    armed <= 1'b0;
                end else if (count_en && (cnt < thr)) begin
                    cnt <= cnt + 1'b1;
                    if ((cnt + 1'b1) == thr) begin
                        idle_evt <= 1'b1;
                    end
                end
            end
        end
    end

    AST_IDLE_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |-> $past(bit_tick && bit_level)); // R5

    AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !bit_level && !stop_arm) |=> (cnt == '0)); // R12

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_BITS)); // R5

endmodule

// File: rtl/rxw_wake.sv
// Module: standby and wakeup control.
// Holds the standby state that software requests. Clears it when the
// selected wakeup condition occurs, and gates character delivery and idle
// flagging while in standby. Assumes sby_req is a single-cycle strobe.
module rxw_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic sby_req,
    input  logic wake_sel,
    input  logic char_done,
    input  logic char_msb,
    input  logic idle_evt,
    output logic standby,
    output logic sby_hw_clr,
    output logic accept,
    output logic idle_set
);
    import rxw_pkg::*;

    wake_e mode;
    logic  wake_hit;
    logic  addr_mark;

    assign mode      = wake_e'(wake_sel);
    // An address-marked character completes.
    assign addr_mark = char_done && char_msb;
    // The selected wakeup condition seen while in standby.
    assign wake_hit  = standby && ((mode == WAKE_ADDR) ? addr_mark : idle_evt);
    // Characters pass when awake, or when they are the wakeup mark itself.
    assign accept    = char_done && (!standby || ((mode == WAKE_ADDR) && char_msb));
    // Idle events only flag when awake.
    assign idle_set  = idle_evt && !standby;

    // Enter standby on request, leave it on the wakeup condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby    <= 1'b0;
            sby_hw_clr <= 1'b0;
        end else begin
            sby_hw_clr <= wake_hit && !sby_req;
            if (sby_req) begin
                standby <= 1'b1;
            end else if (wake_hit) begin
                standby <= 1'b0;
            end
        end
    end

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sby_hw_clr |-> (!standby && $past(standby))); // R9

    AST_ADDR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && wake_sel && char_done && char_msb && !sby_req) |=> !standby); // R10

    AST_SBY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !wake_sel && char_done) |-> !accept); // R8

    AST_REQ_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        sby_req |=> standby); // R8

endmodule

// File: rtl/rxw_flags.sv
// Module: receive status flags and holding register.
// Keeps the receive-full, overrun and idle flags and the held character.
// Implements the status-read-then-data-access clear sequence, clearing only
// the flags captured at the status read. Assumes strobes last one cycle.
module rxw_flags #(
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              idle_set,
    input  logic              char_done,
    input  logic              st_rd,
    input  logic              dr_acc,
    output logic              full,
    output logic              ovr,
    output logic              idle,
    output logic [DATA_W-1:0] rd_data
);
    import rxw_pkg::*;

    rxw_snap_t snap;
    logic      idle_ok;
    logic      clr_full;
    logic      clr_ovr;
    logic      clr_idle;
    logic      load;

    // Second step of the sequence clears what the first step saw.
    assign clr_full = dr_acc && snap.full;
    assign clr_ovr  = dr_acc && snap.ovr;
    assign clr_idle = dr_acc && snap.idle;
    // A character is stored when the holder is free or being freed.
    assign load     = accept && (!full || clr_full);

    // Capture flags on status read, drop the capture on data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (st_rd) begin
            snap <= '{full: full, ovr: ovr, idle: idle};
        end else if (dr_acc) begin
            snap <= '0;
        end
    end

    // Receive-full flag and held data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            rd_data <= '0;
        end else begin
            if (load) begin
                rd_data <= rx_data;
            end
            if (accept) begin
                full <= 1'b1;
            end else if (clr_full) begin
                full <= 1'b0;
            end
        end
    end

    // Overrun flag: a delivered character found the holder occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (accept && !load) begin
            ovr <= 1'b1;
        end else if (clr_ovr) begin
            ovr <= 1'b0;
        end
    end

    // Idle flag and its rearm condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle    <= 1'b0;
            idle_ok <= 1'b0;
        end else begin
            if (idle_set && idle_ok) begin
                idle <= 1'b1;
            end else if (clr_idle) begin
                idle <= 1'b0;
            end
            if (char_done) begin
                idle_ok <= 1'b1;
            end else if (clr_idle) begin
                idle_ok <= 1'b0;
            end
        end
    end

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (full && accept && !clr_full) |=> $stable(rd_data)); // R3

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full)); // R3

    AST_IDLE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(idle_ok)); // R7

    AST_CLEAR_BY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(dr_acc)); // R4

endmodule

// File: rtl/rxw_wake_idle.sv
// Module: top of the receiver wakeup and idle logic.
// Connects the idle counter, the standby controller and the flag block,
// and forms the combined receiver interrupt. Assumes the receiver core
// supplies one bit strobe per bit and char_done on the stop-bit strobe.
module rxw_wake_idle #(
    parameter int unsigned DATA_W     = 9,
    parameter int unsigned IDLE_BITS8 = 10,
    parameter int unsigned IDLE_BITS9 = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              bit_level,
    input  logic              char_done,
    input  logic              stop_ok,
    input  logic              char_msb,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ctl_wake_sel,
    input  logic              ctl_ilt,
    input  logic              ctl_nine,
    input  logic              sby_req,
    input  logic              rie,
    input  logic              ilie,
    input  logic              st_rd,
    input  logic              dr_acc,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              rx_idle,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_irq,
    output logic              standby,
    output logic              sby_hw_clr
);
    logic idle_evt;
    logic accept;
    logic idle_set;

    rxw_idle_cnt #(
        .IDLE_BITS8 (IDLE_BITS8),
        .IDLE_BITS9 (IDLE_BITS9)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .bit_level (bit_level),
        .char_done (char_done),
        .stop_ok   (stop_ok),
        .ilt       (ctl_ilt),
        .nine      (ctl_nine),
        .idle_evt  (idle_evt)
    );

    rxw_wake u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .sby_req    (sby_req),
        .wake_sel   (ctl_wake_sel),
        .char_done  (char_done),
        .char_msb   (char_msb),
        .idle_evt   (idle_evt),
        .standby    (standby),
        .sby_hw_clr (sby_hw_clr),
        .accept     (accept),
        .idle_set   (idle_set)
    );

    rxw_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .rx_data   (rx_data),
        .idle_set  (idle_set),
        .char_done (char_done),
        .st_rd     (st_rd),
        .dr_acc    (dr_acc),
        .full      (rx_full),
        .ovr       (rx_ovr),
        .idle      (rx_idle),
        .rd_data   (rd_data)
    );

    // Combined receiver interrupt, silenced during standby.
    always_comb begin
        rx_irq = !standby && ((rie && (rx_full || rx_ovr)) || (ilie && rx_idle));
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_full || rx_ovr || rx_idle)); // R11

    AST_SBY_NO_IDLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(standby) && standby) |-> !$rose(rx_idle)); // R8

endmodule

// File: tb/rxw_wake_idle_bench.sv
module rxw_wake_idle_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, bit_level = 0, char_done = 0, stop_ok = 0, char_msb = 0;
    logic [DW-1:0] rx_data = '0;
    logic ctl_wake_sel = 0, ctl_ilt = 0, ctl_nine = 0, sby_req = 0;
    logic rie = 0, ilie = 0, st_rd = 0, dr_acc = 0;
    logic rx_full, rx_ovr, rx_idle, rx_irq, standby, sby_hw_clr;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    int n_wake   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxw_wake_idle u_rxw_wake_idle (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_level(bit_level),
        .char_done(char_done), .stop_ok(stop_ok), .char_msb(char_msb),
        .rx_data(rx_data), .ctl_wake_sel(ctl_wake_sel), .ctl_ilt(ctl_ilt),
        .ctl_nine(ctl_nine), .sby_req(sby_req), .rie(rie), .ilie(ilie),
        .st_rd(st_rd), .dr_acc(dr_acc), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .rx_idle(rx_idle), .rd_data(rd_data), .rx_irq(rx_irq),
        .standby(standby), .sby_hw_clr(sby_hw_clr)
    );

    always @(posedge clk) if (rst_n && sby_hw_clr) n_wake++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        {bit_tick, bit_level, char_done, stop_ok, char_msb} = '0;
        rx_data = '0;
        {ctl_wake_sel, ctl_ilt, ctl_nine, sby_req, rie, ilie, st_rd, dr_acc} = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_wake = 0;
    endtask

    task automatic tick(input logic lvl);
        bit_tick = 1; bit_level = lvl;
        @(negedge clk);
        bit_tick = 0; bit_level = 0;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic send_char(input logic [DW-1:0] d, input logic msb);
        int nb;
        nb = ctl_nine ? 9 : 8;
        tick(1'b0);
        for (int i = 0; i < nb; i++) tick(d[i]);
        bit_tick = 1; bit_level = 1; char_done = 1; stop_ok = 1;
        rx_data = d; char_msb = msb;
        @(negedge clk);
        bit_tick = 0; bit_level = 0; char_done = 0; stop_ok = 0; char_msb = 0;
        settle();
    endtask

    task automatic do_st_rd();
        st_rd = 1; @(negedge clk); st_rd = 0; @(negedge clk);
    endtask

    task automatic do_dr_acc();
        dr_acc = 1; @(negedge clk); dr_acc = 0; @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 full", rx_full, 0);
        chk("R1 ovr", rx_ovr, 0);
        chk("R1 idle", rx_idle, 0);
        chk("R1 standby", standby, 0);
        chk("R1 hwclr", sby_hw_clr, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R1 data", rd_data, 0);
    endtask

    task automatic t_accept_overrun_clear();
        do_reset();
        rie = 1;
        send_char(9'h05A, 1'b0);
        chk("R2 full", rx_full, 1);
        chk("R2 data", rd_data, 9'h05A);
        chk("R11 irq full", rx_irq, 1);
        send_char(9'h033, 1'b0);
        chk("R3 ovr", rx_ovr, 1);
        chk("R3 data kept", rd_data, 9'h05A);
        do_dr_acc();
        chk("R4 access alone keeps full", rx_full, 1);
        do_st_rd();
        do_dr_acc();
        chk("R4 full cleared", rx_full, 0);
        chk("R4 ovr cleared", rx_ovr, 0);
        chk("R11 irq low", rx_irq, 0);
        do_st_rd();
        send_char(9'h011, 1'b0);
        do_dr_acc();
        chk("R4 late flag survives", rx_full, 1);
        chk("R2 new data", rd_data, 9'h011);
    endtask

    task automatic t_idle_after_start();
        do_reset();
        ilie = 1;
        send_char(9'h0FF, 1'b1);
        chk("R6 nine ones no idle", rx_idle, 0);
        ones(1); settle();
        chk("R6 trailing ones count", rx_idle, 1);
        chk("R11 idle irq", rx_irq, 1);
        do_st_rd(); do_dr_acc();
        chk("R4 idle cleared", rx_idle, 0);
        tick(1'b0); ones(12); settle();
        chk("R7 no idle without char", rx_idle, 0);
        send_char(9'h0FF, 1'b1);
        ones(1); settle();
        chk("R7 idle after new char", rx_idle, 1);
    endtask

    task automatic t_zero_restart();
        do_reset();
        send_char(9'h0FF, 1'b1);
        tick(1'b0);
        ones(9); settle();
        chk("R12 count restarted", rx_idle, 0);
        ones(1); settle();
        chk("R12 idle at ten", rx_idle, 1);
    endtask

    task automatic t_idle_after_stop();
        do_reset();
        ctl_ilt = 1;
        send_char(9'h0FF, 1'b1);
        ones(1); settle();
        chk("R6 trailing ones ignored", rx_idle, 0);
        ones(8); settle();
        chk("R5 nine after stop", rx_idle, 0);
        ones(1); settle();
        chk("R5 ten after stop", rx_idle, 1);
        chk("R11 ilie off", rx_irq, 0);
    endtask

    task automatic t_nine_bit();
        do_reset();
        ctl_ilt = 1; ctl_nine = 1;
        send_char(9'h1FF, 1'b1);
        ones(10); settle();
        chk("R5 ten in nine-bit", rx_idle, 0);
        ones(1); settle();
        chk("R5 eleven in nine-bit", rx_idle, 1);
    endtask

    task automatic t_wake_idle();
        do_reset();
        rie = 1; ilie = 1;
        sby_req = 1; @(negedge clk); sby_req = 0; @(negedge clk);
        chk("R8 standby set", standby, 1);
        send_char(9'h042, 1'b0);
        chk("R8 no full", rx_full, 0);
        chk("R8 no data", rd_data, 0);
        chk("R8 irq quiet", rx_irq, 0);
        ones(8); settle();
        chk("R9 still standby", standby, 1);
        ones(1); settle();
        chk("R9 woke", standby, 0);
        chk("R9 one pulse", n_wake, 1);
        chk("R9 no idle flag", rx_idle, 0);
    endtask

    task automatic t_wake_addr();
        do_reset();
        rie = 1; ilie = 1; ctl_wake_sel = 1;
        sby_req = 1; @(negedge clk); sby_req = 0; @(negedge clk);
        send_char(9'h021, 1'b0);
        chk("R10 plain char ignored", standby, 1);
        chk("R10 no full", rx_full, 0);
        ones(10); settle();
        chk("R8 idle not flagged", rx_idle, 0);
        chk("R8 idle no wake", standby, 1);
        send_char(9'h0A5, 1'b1);
        chk("R10 woke", standby, 0);
        chk("R10 full", rx_full, 1);
        chk("R10 data", rd_data, 9'h0A5);
        chk("R10 one pulse", n_wake, 1);
        chk("R11 irq after wake", rx_irq, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_accept_overrun_clear();
        t_idle_after_start();
        t_zero_restart();
        t_idle_after_stop();
        t_nine_bit();
        t_wake_idle();
        t_wake_addr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule